// File: doc/BRIEF.md
# ACPI sleep-state power-path sequencer

This block turns three system power-management lines into one of three power states: full power (S0), suspend-to-memory (S3) or soft off (S5). It drives the enables of two supply paths for each of two rails. The dual rail can be fed by a main switch or by a standby regulator. The memory rail can be fed by a main pass device or by a standby regulator.

The two rails change source in different ways. On the dual rail the old path goes off first. Both paths then stay off for a programmed number of cycles, and that number depends on the direction of the change. On the memory rail the new path comes on first, and both paths stay on for a programmed number of cycles.

The decoder keeps a history. While the block is in soft off, an input code that asks for suspend is refused, and only the full-power code brings the block out of soft off. All three inputs pass through a synchroniser and a stability filter before they are decoded. A fault input turns every enable off at once.

Top module: `pwr_path_seq`

## Requirements
- R1: Input code 111 ({pwr_ok_i, slp3_n_i, slp5_n_i}) gives state S0 (pwr_state_o = 01): dual_main_en_o = 1 and mem_main_en_o = 1, and both standby enables are 0.
- R2: With slp5_n_i = 1 and pwr_ok_i, slp3_n_i not both 1, starting from S0 or S3, the state becomes S3 (pwr_state_o = 10): dual_stby_en_o = 1 and mem_stby_en_o = 1, and both main enables are 0.
- R3: With slp5_n_i = 0 and a code other than 110, the state is S5 (pwr_state_o = 11): dual_stby_en_o = 1 and both memory enables are 0.
- R4: Code 110 gives pwr_state_o = 11 with dual_main_en_o = 1 and both memory enables 0.
- R5: In S5, or after code 110, an S3 code leaves pwr_state_o at 11 and leaves the enables unchanged. Only code 111 leaves this state.
- R6: dual_main_en_o and dual_stby_en_o are never 1 in the same cycle.
- R7: When the dual rail changes from main to standby, both dual enables are 0 for exactly DT_M2S_CYC cycles.
- R8: When the dual rail changes from standby to main, both dual enables are 0 for exactly DT_S2M_CYC cycles.
- R9: When the memory rail changes between main and standby, both memory enables are 1 for exactly OVL_CYC cycles. On entry to S5 both memory enables go to 0 with no overlap.
- R10: An input pulse that lasts fewer than FILT_CYCLES cycles does not change the state or any enable.
- R11: During reset, and after reset until the first filtered code is decoded, pwr_state_o = 00 and all enables are 0.
- R12: While fault_off_i = 1, all enables are 0 in the same cycle. After release, the rail targets are restored on the next clock edge with no deadtime or overlap applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Main supply good, asynchronous |
| slp3_n_i | input | 1 | Suspend request, active low, asynchronous |
| slp5_n_i | input | 1 | Soft-off request, active low, asynchronous |
| fault_off_i | input | 1 | Forces all enables off while high |
| dual_main_en_o | output | 1 | Dual rail main switch enable |
| dual_stby_en_o | output | 1 | Dual rail standby regulator enable |
| mem_main_en_o | output | 1 | Memory rail main pass enable |
| mem_stby_en_o | output | 1 | Memory rail standby regulator enable |
| pwr_state_o | output | 2 | 00 not yet decoded, 01 S0, 10 S3, 11 S5 |

## Verification
Every ordered pair of the eight input codes is applied: first one code, then the other. This separates a plain combinational decode from one that keeps history, because the S3 codes must give different results after S5 or code 110 than after S0 or S3.

Changes between S0 and S3 in both directions, and from S0 to S5, are stepped one cycle at a time. The bench counts the off cycles and the overlap cycles in each case, so the two deadtime directions can be told apart, and so can an overlapped change and an immediate memory shutdown.

Short pulses of one cycle and of FILT_CYCLES-1 cycles show that the filter rejects them. A fault applied and then released shows that the enables drop in the same cycle and come back without a gap.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {PS_INIT, PS_S0, PS_S3, PS_S5, PS_SX} pstate_e;
  typedef enum logic [1:0] {SRC_OFF, SRC_MAIN, SRC_STBY} src_e;
  localparam logic [1:0] STC_NONE = 2'b00;
  localparam logic [1:0] STC_S0   = 2'b01;
  localparam logic [1:0] STC_S3   = 2'b10;
  localparam logic [1:0] STC_S5   = 2'b11;
endpackage

// File: rtl/pps_in_filt.sv
module pps_in_filt #(
  parameter int unsigned W    = 3,
  parameter int unsigned SYNC = 2,
  parameter int unsigned FILT = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] code_o,
  output logic         valid_o
);
  localparam int unsigned CW = (FILT > 1) ? $clog2(FILT) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);

  logic [SYNC-1:0][W-1:0] sq;
  logic [SYNC-1:0]        primed;
  logic [W-1:0]           cand_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq     <= '0;
      primed <= '0;
    end else begin
      sq[0]     <= raw_i;
      primed[0] <= 1'b1;
      for (int i = 1; i < SYNC; i++) begin
        sq[i]     <= sq[i-1];
        primed[i] <= primed[i-1];
      end
    end
  end

  // the filter waits until the synchroniser holds real samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q  <= '0;
      cnt_q   <= '0;
      code_o  <= '0;
      valid_o <= 1'b0;
    end else if (primed[SYNC-1]) begin
      if (sq[SYNC-1] != cand_q) begin
        cand_q <= sq[SYNC-1];
        cnt_q  <= '0;
      end else if (cnt_q != LAST) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        code_o  <= cand_q;
        valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pps_state_dec.sv
module pps_state_dec
  import pps_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] code_i,   // {pwr_ok, slp3_n, slp5_n}
  input  logic       valid_i,
  output pstate_e    state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= PS_INIT;
    end else if (valid_i) begin
      if (code_i == 3'b111) begin
        state_o <= PS_S0;
      end else if (!code_i[0]) begin
        state_o <= (code_i == 3'b110) ? PS_SX : PS_S5;
      end else if (state_o != PS_S5 && state_o != PS_SX) begin
        state_o <= PS_S3;  // S3 refused while in soft off
      end
    end
  end
endmodule

// File: rtl/pps_rail_bbm.sv
module pps_rail_bbm
  import pps_pkg::*;
#(
  parameter int unsigned DT_M2S = 40,
  parameter int unsigned DT_S2M = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  src_e tgt_i,
  output logic main_o,
  output logic stby_o
);
  localparam int unsigned MX = (DT_M2S > DT_S2M) ? DT_M2S : DT_S2M;
  localparam int unsigned CW = $clog2(MX + 1);

  typedef enum logic [1:0] {B_OFF, B_MAIN, B_STBY, B_GAP} bst_e;
  bst_e          st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= B_OFF;
      cnt_q <= '0;
    end else if (fault_i) begin
      st_q  <= B_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        B_OFF: begin
          if (tgt_i == SRC_MAIN)      st_q <= B_MAIN;
          else if (tgt_i == SRC_STBY) st_q <= B_STBY;
        end
        B_MAIN: begin
          if (tgt_i == SRC_OFF) st_q <= B_OFF;
          else if (tgt_i == SRC_STBY) begin
            st_q  <= B_GAP;
            cnt_q <= CW'(DT_M2S - 1);
          end
        end
        B_STBY: begin
          if (tgt_i == SRC_OFF) st_q <= B_OFF;
          else if (tgt_i == SRC_MAIN) begin
            st_q  <= B_GAP;
            cnt_q <= CW'(DT_S2M - 1);
          end
        end
        B_GAP: begin
          if (cnt_q == '0) begin
            unique case (tgt_i)
              SRC_MAIN: st_q <= B_MAIN;
              SRC_STBY: st_q <= B_STBY;
              default:  st_q <= B_OFF;
            endcase
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= B_OFF;
      endcase
    end
  end

  assign main_o = (st_q == B_MAIN);
  assign stby_o = (st_q == B_STBY);
endmodule

// File: rtl/pps_rail_mbb.sv
module pps_rail_mbb
  import pps_pkg::*;
#(
  parameter int unsigned OVL = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  src_e tgt_i,
  output logic main_o,
  output logic stby_o
);
  localparam int unsigned CW = $clog2(OVL + 1);

  typedef enum logic [1:0] {M_OFF, M_MAIN, M_STBY, M_BOTH} mst_e;
  mst_e          st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= M_OFF;
      cnt_q <= '0;
    end else if (fault_i) begin
      st_q  <= M_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        M_OFF: begin
          if (tgt_i == SRC_MAIN)      st_q <= M_MAIN;
          else if (tgt_i == SRC_STBY) st_q <= M_STBY;
        end
        M_MAIN: begin
          if (tgt_i == SRC_OFF) st_q <= M_OFF;
          else if (tgt_i == SRC_STBY) begin
            st_q  <= M_BOTH;
            cnt_q <= CW'(OVL - 1);
          end
        end
        M_STBY: begin
          if (tgt_i == SRC_OFF) st_q <= M_OFF;
          else if (tgt_i == SRC_MAIN) begin
            st_q  <= M_BOTH;
            cnt_q <= CW'(OVL - 1);
          end
        end
        M_BOTH: begin
          if (tgt_i == SRC_OFF) begin
            st_q <= M_OFF;  // shutdown skips the overlap
          end else if (cnt_q == '0) begin
            st_q <= (tgt_i == SRC_MAIN) ? M_MAIN : M_STBY;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= M_OFF;
      endcase
    end
  end

  assign main_o = (st_q == M_MAIN) || (st_q == M_BOTH);
  assign stby_o = (st_q == M_STBY) || (st_q == M_BOTH);
endmodule

// File: rtl/pwr_path_seq.sv
module pwr_path_seq
  import pps_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 3,
  parameter int unsigned DT_M2S_CYC  = 40,
  parameter int unsigned DT_S2M_CYC  = 5,
  parameter int unsigned OVL_CYC     = 30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_ok_i,
  input  logic       slp3_n_i,
  input  logic       slp5_n_i,
  input  logic       fault_off_i,
  output logic       dual_main_en_o,
  output logic       dual_stby_en_o,
  output logic       mem_main_en_o,
  output logic       mem_stby_en_o,
  output logic [1:0] pwr_state_o
);
  logic [2:0] code;
  logic       code_vld;
  pstate_e    pstate;
  src_e       dual_tgt, mem_tgt;
  logic       d_main, d_stby, m_main, m_stby;

  pps_in_filt #(.W(3), .SYNC(SYNC_STAGES), .FILT(FILT_CYCLES)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   ({pwr_ok_i, slp3_n_i, slp5_n_i}),
    .code_o  (code),
    .valid_o (code_vld)
  );

  pps_state_dec u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .code_i  (code),
    .valid_i (code_vld),
    .state_o (pstate)
  );

  always_comb begin
    unique case (pstate)
      PS_S0:   begin dual_tgt = SRC_MAIN; mem_tgt = SRC_MAIN; end
      PS_S3:   begin dual_tgt = SRC_STBY; mem_tgt = SRC_STBY; end
      PS_S5:   begin dual_tgt = SRC_STBY; mem_tgt = SRC_OFF;  end
      PS_SX:   begin dual_tgt = SRC_MAIN; mem_tgt = SRC_OFF;  end
      default: begin dual_tgt = SRC_OFF;  mem_tgt = SRC_OFF;  end
    endcase
  end

  always_comb begin
    unique case (pstate)
      PS_S0:        pwr_state_o = STC_S0;
      PS_S3:        pwr_state_o = STC_S3;
      PS_S5, PS_SX: pwr_state_o = STC_S5;
      default:      pwr_state_o = STC_NONE;
    endcase
  end

  pps_rail_bbm #(.DT_M2S(DT_M2S_CYC), .DT_S2M(DT_S2M_CYC)) u_dual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (fault_off_i),
    .tgt_i   (dual_tgt),
    .main_o  (d_main),
    .stby_o  (d_stby)
  );

  pps_rail_mbb #(.OVL(OVL_CYC)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (fault_off_i),
    .tgt_i   (mem_tgt),
    .main_o  (m_main),
    .stby_o  (m_stby)
  );

  // fault gating is combinational so it takes effect in the same cycle
  assign dual_main_en_o = d_main & ~fault_off_i;
  assign dual_stby_en_o = d_stby & ~fault_off_i;
  assign mem_main_en_o  = m_main & ~fault_off_i;
  assign mem_stby_en_o  = m_stby & ~fault_off_i;
endmodule

// File: rtl/pwr_path_seq_chk.sv
module pwr_path_seq_chk #(
  parameter int unsigned DT_M2S_CYC = 40,
  parameter int unsigned DT_S2M_CYC = 5,
  parameter int unsigned OVL_CYC    = 30
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fault_off_i,
  input logic       dual_main_en_o,
  input logic       dual_stby_en_o,
  input logic       mem_main_en_o,
  input logic       mem_stby_en_o,
  input logic [1:0] pwr_state_o
);
  localparam int unsigned MX0 = (DT_M2S_CYC > DT_S2M_CYC) ? DT_M2S_CYC : DT_S2M_CYC;
  localparam int unsigned MX  = (MX0 > OVL_CYC) ? MX0 : OVL_CYC;
  localparam int unsigned CW  = $clog2(MX + 2) + 1;

  logic [CW-1:0] gap_cnt, ovl_cnt;
  logic [1:0]    last_src;  // 0 none, 1 main, 2 standby

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_cnt  <= '0;
      ovl_cnt  <= '0;
      last_src <= 2'd0;
    end else begin
      if (fault_off_i)         last_src <= 2'd0;
      else if (dual_main_en_o) last_src <= 2'd1;
      else if (dual_stby_en_o) last_src <= 2'd2;
      if (dual_main_en_o || dual_stby_en_o) gap_cnt <= '0;
      else if (gap_cnt != '1)               gap_cnt <= gap_cnt + 1'b1;
      if (!(mem_main_en_o && mem_stby_en_o)) ovl_cnt <= '0;
      else if (ovl_cnt != '1)                ovl_cnt <= ovl_cnt + 1'b1;
    end
  end

  a_r6_dual_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dual_main_en_o && dual_stby_en_o));

  a_r7_m2s_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dual_stby_en_o) && last_src == 2'd1) |-> gap_cnt == CW'(DT_M2S_CYC));

  a_r8_s2m_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dual_main_en_o) && last_src == 2'd2) |-> gap_cnt == CW'(DT_S2M_CYC));

  a_r9_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($fell(mem_main_en_o) && mem_stby_en_o) || ($fell(mem_stby_en_o) && mem_main_en_o))
      |-> ovl_cnt == CW'(OVL_CYC));

  a_r9_overlap_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_cnt <= CW'(OVL_CYC));

  a_r5_s5_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_state_o == 2'b11 |=> pwr_state_o != 2'b10);

  a_r3_mem_off_s5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'b11 && $past(pwr_state_o) == 2'b11) |-> !mem_main_en_o && !mem_stby_en_o);

  a_r11_init_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_state_o == 2'b00 |-> !(dual_main_en_o || dual_stby_en_o || mem_main_en_o || mem_stby_en_o));

  a_r12_fault_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_off_i |-> !(dual_main_en_o || dual_stby_en_o || mem_main_en_o || mem_stby_en_o));
endmodule

bind pwr_path_seq pwr_path_seq_chk #(
  .DT_M2S_CYC (DT_M2S_CYC),
  .DT_S2M_CYC (DT_S2M_CYC),
  .OVL_CYC    (OVL_CYC)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fault_off_i    (fault_off_i),
  .dual_main_en_o (dual_main_en_o),
  .dual_stby_en_o (dual_stby_en_o),
  .mem_main_en_o  (mem_main_en_o),
  .mem_stby_en_o  (mem_stby_en_o),
  .pwr_state_o    (pwr_state_o)
);

// File: tb/pwr_path_seq_tb.sv
module pwr_path_seq_tb;
  localparam int FILT = 3;
  localparam int DM2S = 6;
  localparam int DS2M = 3;
  localparam int OVL  = 4;
  localparam int SETTLE = 30;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_ok_i = 1'b0, slp3_n_i = 1'b0, slp5_n_i = 1'b0, fault_off_i = 1'b0;
  logic dual_main_en_o, dual_stby_en_o, mem_main_en_o, mem_stby_en_o;
  logic [1:0] pwr_state_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int mst = 0;  // model: 0 init, 1 S0, 2 S3, 3 S5, 4 code-110 state

  always #4 clk_i = ~clk_i;

  pwr_path_seq #(
    .SYNC_STAGES (2),
    .FILT_CYCLES (FILT),
    .DT_M2S_CYC  (DM2S),
    .DT_S2M_CYC  (DS2M),
    .OVL_CYC     (OVL)
  ) u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pwr_ok_i       (pwr_ok_i),
    .slp3_n_i       (slp3_n_i),
    .slp5_n_i       (slp5_n_i),
    .fault_off_i    (fault_off_i),
    .dual_main_en_o (dual_main_en_o),
    .dual_stby_en_o (dual_stby_en_o),
    .mem_main_en_o  (mem_main_en_o),
    .mem_stby_en_o  (mem_stby_en_o),
    .pwr_state_o    (pwr_state_o)
  );

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic drive(input logic [2:0] c);
    {pwr_ok_i, slp3_n_i, slp5_n_i} = c;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int model_next(input int cur, input logic [2:0] c);
    if (c == 3'b111) return 1;
    if (!c[0]) return (c == 3'b110) ? 4 : 3;
    if (cur == 3 || cur == 4) return cur;
    return 2;
  endfunction

  // packed {state[1:0], dual_main, dual_stby, mem_main, mem_stby}
  function automatic int model_outs(input int st);
    case (st)
      1: return {2'b01, 4'b1010};
      2: return {2'b10, 4'b0101};
      3: return {2'b11, 4'b0100};
      4: return {2'b11, 4'b1000};
      default: return 0;
    endcase
  endfunction

  function automatic int dut_outs();
    return int'({pwr_state_o, dual_main_en_o, dual_stby_en_o, mem_main_en_o, mem_stby_en_o});
  endfunction

  function automatic string tag_for(input int prev, input logic [2:0] c);
    if (c == 3'b111) return "R1";
    if (c == 3'b110) return "R4";
    if (!c[0]) return "R3";
    if (prev == 3 || prev == 4) return "R5";
    return "R2";
  endfunction

  task automatic run_count(input logic [2:0] c, output int dgap, output int movl, output int excl);
    drive(c);
    dgap = 0; movl = 0; excl = 0;
    repeat (50) begin
      step();
      if (!dual_main_en_o && !dual_stby_en_o) dgap++;
      if (mem_main_en_o && mem_stby_en_o) movl++;
      if (dual_main_en_o && dual_stby_en_o) excl++;
    end
    mst = model_next(mst, c);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int dg, mo, ex, prev;
    drive(3'b000);
    repeat (3) step();
    // R11 during reset
    chk("R11", "outs in reset", dut_outs(), 0);
    rst_ni = 1'b1;
    step();
    chk("R11", "outs before first decode", dut_outs(), 0);
    repeat (SETTLE) step();
    mst = model_next(mst, 3'b000);
    chk("R3", "after reset code 000", dut_outs(), model_outs(mst));

    // sweep of all ordered code pairs
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        drive(3'(a));
        repeat (SETTLE) step();
        prev = mst;
        mst = model_next(mst, 3'(a));
        chk(tag_for(prev, 3'(a)), "sweep first", dut_outs(), model_outs(mst));
        drive(3'(b));
        repeat (SETTLE) step();
        prev = mst;
        mst = model_next(mst, 3'(b));
        chk(tag_for(prev, 3'(b)), "sweep second", dut_outs(), model_outs(mst));
      end
    end

    // timing of source changes
    drive(3'b111);
    repeat (SETTLE) step();
    mst = model_next(mst, 3'b111);
    chk("R1", "enter S0", dut_outs(), model_outs(mst));

    run_count(3'b011, dg, mo, ex);
    chk("R7", "main to standby gap", dg, DM2S);
    chk("R9", "S0 to S3 overlap", mo, OVL);
    chk("R6", "dual both on S0->S3", ex, 0);
    chk("R2", "S3 settled", dut_outs(), model_outs(mst));

    run_count(3'b111, dg, mo, ex);
    chk("R8", "standby to main gap", dg, DS2M);
    chk("R9", "S3 to S0 overlap", mo, OVL);
    chk("R6", "dual both on S3->S0", ex, 0);

    run_count(3'b010, dg, mo, ex);
    chk("R7", "S0 to S5 gap", dg, DM2S);
    chk("R9", "S0 to S5 no overlap", mo, 0);
    chk("R3", "S5 settled", dut_outs(), model_outs(mst));

    run_count(3'b101, dg, mo, ex);
    chk("R5", "S3 code in S5 no gap", dg, 0);
    chk("R5", "S3 code in S5 outs", dut_outs(), model_outs(mst));

    run_count(3'b111, dg, mo, ex);
    chk("R1", "S5 to S0", dut_outs(), model_outs(mst));

    // short pulses are filtered out
    drive(3'b011);
    step();
    drive(3'b111);
    dg = 0;
    repeat (SETTLE) begin
      step();
      if (!dual_main_en_o) dg++;
    end
    chk("R10", "1-cycle pulse dual main drop", dg, 0);
    chk("R10", "1-cycle pulse outs", dut_outs(), model_outs(mst));

    drive(3'b010);
    repeat (FILT - 1) step();
    drive(3'b111);
    dg = 0;
    repeat (SETTLE) begin
      step();
      if (!dual_main_en_o || !mem_main_en_o) dg++;
    end
    chk("R10", "short pulse enable drop", dg, 0);
    chk("R10", "short pulse outs", dut_outs(), model_outs(mst));

    // fault forces off at once, then resumes without gap
    step();
    fault_off_i = 1'b1;
    #1;
    chk("R12", "fault same cycle", dut_outs(), {2'b01, 4'b0000});
    repeat (5) step();
    chk("R12", "fault held", dut_outs(), {2'b01, 4'b0000});
    fault_off_i = 1'b0;
    step();
    chk("R12", "resume after fault", dut_outs(), model_outs(mst));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule